// File: doc/BRIEF.md
# Memory-Space Address Decoder with Reserved-Region Trap

This block sits between a 24-bit signal-processing core and its three memory spaces: program, X-data and Y-data. For every access the core presents a 16-bit address, a space code and an operation code (fetch, read or write), along with a flag that says whether the core is in bootstrap mode. The decoder works out whether the address lands in the boot ROM, in internal RAM or in a reserved area. It then raises the write enable of the right array, or it returns the read data one clock later.

Reserved areas behave in two different ways. The upper reserved range of each space answers a read or fetch with the illegal-instruction word 0x000005 and pulses a trap flag, so the core ends up in its illegal-instruction handler. The lower reserved window in X and Y returns an unspecified word and raises no flag. Writes to any reserved or ROM address never reach an array.

While bootstrap mode is on, the first 256 words of program RAM are write-only, so a loader can fill them but nothing can read them back. A read that this rule blocks returns zero and raises a separate violation flag. Every region boundary is a parameter. The arrays themselves sit outside the block: they read combinationally at `mem_addr` and write on the clock edge when their enable is high.

Top module: `memdec_top`

## Requirements
- R1: Program addresses 0 to 31 select the boot ROM. A fetch or read there returns `rom_rdata`, in bootstrap mode and outside it.
- R2: A fetch or read (op 01 or 10) of a RAM address returns that space's array data on `rdata`, with `rvalid` high, in the cycle after the request. Space codes are 00 program, 01 X and 10 Y. RAM is program 32 up to 0x0BFF, X/Y 0 up to 0x07FF, X 0x2000 up to 0x2DFF, and Y 0x2000 up to 0x27FF.
- R3: A write (op 11) to a RAM address raises exactly one of `p_we`/`x_we`/`y_we`, combinationally, in the same cycle. A write to ROM, to any reserved address or with space code 11 raises none.
- R4: A read from X address 0x2E00 or above returns 0x000005 with `illegal_trap` high.
- R5: A read from Y address 0x2800 or above returns 0x000005 with `illegal_trap` high.
- R6: A fetch or read from program address 0x0C00 or above returns 0x000005 with `illegal_trap` high.
- R7: While `boot_mode` is high, a fetch or read of program addresses 32 to 287 returns zero and raises `access_violation` without `illegal_trap`. Writes to those addresses still take effect.
- R8: Bootstrap mode does not change access to program RAM at address 288 or above.
- R9: A read from X or Y addresses 0x0800 to 0x1FFF, or with space code 11, raises neither `illegal_trap` nor `access_violation`. Its data is unspecified.
- R10: `rvalid`, `illegal_trap` and `access_violation` are high only in the cycle after a fetch or read. They are low after idle (op 00) or write cycles.
- R11: While `rst` is high, `rdata`, `rvalid`, `illegal_trap` and `access_violation` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Access address |
| space | input | 2 | 00 program, 01 X, 10 Y, 11 none |
| op | input | 2 | 00 idle, 01 fetch, 10 read, 11 write |
| boot_mode | input | 1 | Bootstrap mode flag |
| wdata | input | 24 | Write data from the core |
| rom_rdata | input | 24 | Boot ROM word at `mem_addr` |
| p_rdata | input | 24 | Program RAM word at `mem_addr` |
| x_rdata | input | 24 | X RAM word at `mem_addr` |
| y_rdata | input | 24 | Y RAM word at `mem_addr` |
| mem_addr | output | 16 | Address to all arrays |
| mem_wdata | output | 24 | Write data to all arrays |
| p_we | output | 1 | Program RAM write enable |
| x_we | output | 1 | X RAM write enable |
| y_we | output | 1 | Y RAM write enable |
| rdata | output | 24 | Registered read data |
| rvalid | output | 1 | Read data valid |
| illegal_trap | output | 1 | Illegal-word returned this cycle |
| access_violation | output | 1 | Bootstrap-protected read blocked this cycle |

## Verification
The bench probes every boundary from both sides: 31/32, 287/288, 0x0BFF/0x0C00, 0x07FF/0x0800, 0x1FFF/0x2000, 0x2DFF/0x2E00 and 0x27FF/0x2800. A comparison that is off by one would trap on a valid RAM word, or leak array data from a reserved address. Bootstrap-mode writes into the protected window are read back after the mode ends. This catches a decoder that blocks writes along with reads. It also catches one that drops the violation flag, or replaces the flag with a trap. Back-to-back trap reads followed by idle cycles show whether the trap and valid flags stick or stretch.

// File: rtl/memdec_pkg.sv
package memdec_pkg;
  typedef enum logic [1:0] {SP_PROG = 2'd0, SP_X = 2'd1, SP_Y = 2'd2, SP_NONE = 2'd3} space_t;
  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_FETCH = 2'd1, OP_READ = 2'd2, OP_WRITE = 2'd3} op_t;
  typedef enum logic [2:0] {RG_ROM, RG_RAM, RG_HOLE, RG_TRAP, RG_LOCKED} region_t;
  localparam logic [23:0] ILLEGAL_WORD = 24'h000005;
endpackage

// File: rtl/memdec_prog_map.sv
module memdec_prog_map
  import memdec_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned ROM_WORDS  = 32,
  parameter int unsigned PROT_WORDS = 256,
  parameter int unsigned PRAM_TOP   = 32'h0C00
) (
  input  logic [AW-1:0] addr,
  input  logic          boot_mode,
  output region_t       region
);
  localparam logic [AW-1:0] ROM_END  = AW'(ROM_WORDS);
  localparam logic [AW-1:0] PROT_END = AW'(ROM_WORDS + PROT_WORDS);
  localparam logic [AW-1:0] RAM_END  = AW'(PRAM_TOP);

  always_comb begin
    if (addr < ROM_END)                     region = RG_ROM;
    else if (addr >= RAM_END)               region = RG_TRAP;
    else if (boot_mode && addr < PROT_END)  region = RG_LOCKED;
    else                                    region = RG_RAM;
  end
endmodule

// File: rtl/memdec_data_map.sv
module memdec_data_map
  import memdec_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned RAM_TOP  = 32'h0800,
  parameter int unsigned GAP_END  = 32'h2000,
  parameter int unsigned RSV_BASE = 32'h2E00
) (
  input  logic [AW-1:0] addr,
  output region_t       region
);
  localparam logic [AW-1:0] LO_END = AW'(RAM_TOP);
  localparam logic [AW-1:0] HOLE_END = AW'(GAP_END);
  localparam logic [AW-1:0] HI_END = AW'(RSV_BASE);

  always_comb begin
    if (addr < LO_END)         region = RG_RAM;
    else if (addr < HOLE_END)  region = RG_HOLE;
    else if (addr < HI_END)    region = RG_RAM;
    else                       region = RG_TRAP;
  end
endmodule

// File: rtl/memdec_resp.sv
module memdec_resp
  import memdec_pkg::*;
#(
  parameter int unsigned DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  region_t       region,
  input  logic [DW-1:0] src,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          trap,
  output logic          viol
);
  localparam logic [DW-1:0] ILLEGAL = DW'(ILLEGAL_WORD);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      trap   <= 1'b0;
      viol   <= 1'b0;
    end else begin
      rvalid <= rd_en;
      trap   <= rd_en && (region == RG_TRAP);
      viol   <= rd_en && (region == RG_LOCKED);
      if (rd_en) begin
        case (region)
          RG_ROM, RG_RAM: rdata <= src;
          RG_TRAP:        rdata <= ILLEGAL;
          default:        rdata <= '0;
        endcase
      end else begin
        rdata <= '0;
      end
    end
  end

  a_r4_trap_word: assert property (@(posedge clk) disable iff (rst) trap |-> rdata == ILLEGAL);
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst) !(trap && viol));
  a_r10_flags_need_valid: assert property (@(posedge clk) disable iff (rst) (trap || viol) |-> rvalid);
endmodule

// File: rtl/memdec_top.sv
module memdec_top
  import memdec_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned DW         = 24,
  parameter int unsigned ROM_WORDS  = 32,
  parameter int unsigned PROT_WORDS = 256,
  parameter int unsigned PRAM_TOP   = 32'h0C00,
  parameter int unsigned X_RAM_TOP  = 32'h0800,
  parameter int unsigned Y_RAM_TOP  = 32'h0800,
  parameter int unsigned GAP_END    = 32'h2000,
  parameter int unsigned X_RSV_BASE = 32'h2E00,
  parameter int unsigned Y_RSV_BASE = 32'h2800
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    space,
  input  logic [1:0]    op,
  input  logic          boot_mode,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] rom_rdata,
  input  logic [DW-1:0] p_rdata,
  input  logic [DW-1:0] x_rdata,
  input  logic [DW-1:0] y_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          p_we,
  output logic          x_we,
  output logic          y_we,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          illegal_trap,
  output logic          access_violation
);
  localparam int NDATA = 2;

  region_t       p_region;
  region_t       d_region [NDATA];
  region_t       region;
  logic [DW-1:0] src;
  space_t        sp;
  logic          rd_en, wr_en, writable;

  memdec_prog_map #(
    .AW(AW), .ROM_WORDS(ROM_WORDS), .PROT_WORDS(PROT_WORDS), .PRAM_TOP(PRAM_TOP)
  ) u_pmap (
    .addr(addr), .boot_mode(boot_mode), .region(p_region)
  );

  for (genvar g = 0; g < NDATA; g++) begin : g_dmap
    localparam int unsigned RT = (g == 0) ? X_RAM_TOP : Y_RAM_TOP;
    localparam int unsigned RB = (g == 0) ? X_RSV_BASE : Y_RSV_BASE;
    memdec_data_map #(
      .AW(AW), .RAM_TOP(RT), .GAP_END(GAP_END), .RSV_BASE(RB)
    ) u_dmap (
      .addr(addr), .region(d_region[g])
    );
  end

  always_comb begin
    sp = space_t'(space);
    case (sp)
      SP_PROG: begin
        region = p_region;
        src    = (p_region == RG_ROM) ? rom_rdata : p_rdata;
      end
      SP_X: begin
        region = d_region[0];
        src    = x_rdata;
      end
      SP_Y: begin
        region = d_region[1];
        src    = y_rdata;
      end
      default: begin
        region = RG_HOLE;
        src    = '0;
      end
    endcase
  end

  assign rd_en    = (op == OP_FETCH) || (op == OP_READ);
  assign wr_en    = (op == OP_WRITE);
  assign writable = (region == RG_RAM) || (region == RG_LOCKED);

  assign mem_addr  = addr;
  assign mem_wdata = wdata;
  assign p_we = wr_en && writable && (sp == SP_PROG);
  assign x_we = wr_en && writable && (sp == SP_X);
  assign y_we = wr_en && writable && (sp == SP_Y);

  memdec_resp #(.DW(DW)) u_resp (
    .clk(clk), .rst(rst), .rd_en(rd_en), .region(region), .src(src),
    .rdata(rdata), .rvalid(rvalid), .trap(illegal_trap), .viol(access_violation)
  );

  a_r3_one_enable: assert property (@(posedge clk) disable iff (rst) $onehot0({p_we, x_we, y_we}));
  a_r3_x_rsv_blocked: assert property (@(posedge clk) disable iff (rst)
    (op == OP_WRITE && space == SP_X && addr >= AW'(X_RSV_BASE)) |-> !x_we);
  a_r3_y_rsv_blocked: assert property (@(posedge clk) disable iff (rst)
    (op == OP_WRITE && space == SP_Y && addr >= AW'(Y_RSV_BASE)) |-> !y_we);
  a_r10_read_gives_valid: assert property (@(posedge clk) disable iff (rst)
    (op == OP_READ || op == OP_FETCH) |=> rvalid);
  a_r10_no_read_no_valid: assert property (@(posedge clk) disable iff (rst)
    (op == OP_IDLE || op == OP_WRITE) |=> !rvalid);
  a_r7_viol_needs_boot: assert property (@(posedge clk) disable iff (rst)
    access_violation |-> $past(boot_mode));
endmodule

// File: tb/memdec_top_test.sv
module memdec_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic [1:0]  space = '0;
  logic [1:0]  op = '0;
  logic        boot_mode = 1'b0;
  logic [23:0] wdata = '0;
  logic [23:0] rom_rdata, p_rdata, x_rdata, y_rdata;
  logic [15:0] mem_addr;
  logic [23:0] mem_wdata, rdata;
  logic        p_we, x_we, y_we, rvalid, illegal_trap, access_violation;

  logic [23:0] pmem [65536];
  logic [23:0] xmem [65536];
  logic [23:0] ymem [65536];
  logic [23:0] mp [65536];
  logic [23:0] mx [65536];
  logic [23:0] my [65536];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  memdec_top uut (
    .clk(clk), .rst(rst), .addr(addr), .space(space), .op(op), .boot_mode(boot_mode),
    .wdata(wdata), .rom_rdata(rom_rdata), .p_rdata(p_rdata), .x_rdata(x_rdata),
    .y_rdata(y_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .p_we(p_we),
    .x_we(x_we), .y_we(y_we), .rdata(rdata), .rvalid(rvalid),
    .illegal_trap(illegal_trap), .access_violation(access_violation)
  );

  assign rom_rdata = 24'hA50000 ^ {8'h00, mem_addr};
  assign p_rdata = pmem[mem_addr];
  assign x_rdata = xmem[mem_addr];
  assign y_rdata = ymem[mem_addr];

  always @(posedge clk) begin
    if (p_we) pmem[mem_addr] <= mem_wdata;
    if (x_we) xmem[mem_addr] <= mem_wdata;
    if (y_we) ymem[mem_addr] <= mem_wdata;
  end

  // expected response pending for the next sample point
  bit          have_exp = 0;
  bit          e_valid, e_trap, e_viol, e_chkdata;
  logic [23:0] e_data;
  string       e_tag;

  // 0 rom, 1 ram, 2 unspecified, 3 illegal, 4 boot-protected
  function automatic int kind(input logic [1:0] s, input int a, input bit bm);
    if (s == 2'd0) begin
      if (a < 32) return 0;
      if (a >= 'h0C00) return 3;
      if (bm && a < 288) return 4;
      return 1;
    end
    if (s == 2'd3) return 2;
    if (a >= ((s == 2'd1) ? 'h2E00 : 'h2800)) return 3;
    if (a >= 'h0800 && a < 'h2000) return 2;
    return 1;
  endfunction

  task automatic compare();
    checks++;
    if (rvalid !== e_valid || illegal_trap !== e_trap || access_violation !== e_viol ||
        (e_chkdata && rdata !== e_data)) begin
      errors++;
      $display("FAIL %s: got v=%0b t=%0b av=%0b d=%h exp v=%0b t=%0b av=%0b d=%h",
               e_tag, rvalid, illegal_trap, access_violation, rdata,
               e_valid, e_trap, e_viol, e_data);
    end
  endtask

  task automatic step(input logic [1:0] o, input logic [1:0] s, input int a,
                      input logic [23:0] wd, input bit bm, input string tag);
    int k;
    bit wr, exp_p, exp_x, exp_y;
    @(negedge clk);
    if (have_exp) compare();
    op = o; space = s; addr = a[15:0]; wdata = wd; boot_mode = bm;
    k = kind(s, a, bm);
    e_tag = tag;
    e_valid = (o == 2'd1 || o == 2'd2);
    e_trap = e_valid && k == 3;
    e_viol = e_valid && k == 4;
    e_chkdata = e_valid && k != 2;
    case (k)
      0: e_data = 24'hA50000 ^ a[23:0];
      1: e_data = (s == 2'd0) ? mp[a] : (s == 2'd1) ? mx[a] : my[a];
      3: e_data = 24'h000005;
      default: e_data = 24'h0;
    endcase
    if (!e_valid) e_data = 24'h0;
    have_exp = 1;
    wr = (o == 2'd3) && (k == 1 || k == 4);
    exp_p = wr && s == 2'd0;
    exp_x = wr && s == 2'd1;
    exp_y = wr && s == 2'd2;
    #1;
    checks++;
    if ({p_we, x_we, y_we} !== {exp_p, exp_x, exp_y}) begin
      errors++;
      $display("FAIL %s R3: write enables got %b exp %b", tag, {p_we, x_we, y_we},
               {exp_p, exp_x, exp_y});
    end
    if (exp_p) mp[a] = wd;
    if (exp_x) mx[a] = wd;
    if (exp_y) my[a] = wd;
  endtask

  localparam logic [1:0] IDL = 2'd0, FET = 2'd1, RD = 2'd2, WR = 2'd3;
  localparam logic [1:0] P = 2'd0, X = 2'd1, Y = 2'd2, N = 2'd3;

  initial begin
    for (int i = 0; i < 65536; i++) begin
      pmem[i] = 24'h100000 + 24'(i); mp[i] = 24'h100000 + 24'(i);
      xmem[i] = 24'h200000 + 24'(i); mx[i] = 24'h200000 + 24'(i);
      ymem[i] = 24'h300000 + 24'(i); my[i] = 24'h300000 + 24'(i);
    end
    op = RD; space = X; addr = 16'h2E00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rdata !== 24'h0 || rvalid !== 1'b0 || illegal_trap !== 1'b0 || access_violation !== 1'b0) begin
      errors++;
      $display("FAIL R11: reset outputs got d=%h v=%0b t=%0b av=%0b exp all zero",
               rdata, rvalid, illegal_trap, access_violation);
    end
    op = IDL;
    rst = 1'b0;

    step(FET, P, 0, 0, 0, "R1");
    step(RD,  P, 31, 0, 0, "R1");
    step(FET, P, 32, 0, 0, "R2");
    step(RD,  X, 'h10, 0, 0, "R2");
    step(RD,  Y, 'h07FF, 0, 0, "R2");
    step(RD,  X, 'h2000, 0, 0, "R2");
    step(RD,  X, 'h2DFF, 0, 0, "R2");
    step(RD,  Y, 'h27FF, 0, 0, "R2");
    step(FET, P, 'h0BFF, 0, 0, "R2");
    step(WR,  X, 'h10, 24'h123456, 0, "R3");
    step(RD,  X, 'h10, 0, 0, "R3");
    step(WR,  Y, 'h2400, 24'hABCDEF, 0, "R3");
    step(RD,  Y, 'h2400, 0, 0, "R3");
    step(WR,  P, 'h0200, 24'h0F0F0F, 0, "R3");
    step(FET, P, 'h0200, 0, 0, "R3");
    step(WR,  P, 5, 24'hFFFFFF, 0, "R3");
    step(WR,  X, 'h2E00, 24'h111111, 0, "R3");
    step(WR,  Y, 'h2800, 24'h222222, 0, "R3");
    step(WR,  X, 'h1000, 24'h333333, 0, "R3");
    step(WR,  P, 'h0C00, 24'h444444, 0, "R3");
    step(WR,  N, 'h0010, 24'h555555, 0, "R3");
    step(RD,  P, 5, 0, 0, "R3");
    step(RD,  X, 'h0010, 0, 0, "R3");
    step(RD,  X, 'h2E00, 0, 0, "R4");
    step(RD,  X, 'hFFFF, 0, 0, "R4");
    step(RD,  Y, 'h2800, 0, 0, "R5");
    step(RD,  Y, 'hC000, 0, 0, "R5");
    step(FET, P, 'h0C00, 0, 0, "R6");
    step(RD,  P, 'hFFFF, 0, 0, "R6");
    step(IDL, P, 0, 0, 0, "R10");
    step(IDL, X, 'h2E00, 0, 0, "R10");
    step(RD,  P, 32, 0, 1, "R7");
    step(FET, P, 287, 0, 1, "R7");
    step(WR,  P, 40, 24'h777777, 1, "R7");
    step(WR,  P, 287, 24'h888888, 1, "R7");
    step(RD,  P, 40, 0, 1, "R7");
    step(IDL, P, 0, 0, 1, "R10");
    step(FET, P, 288, 0, 1, "R8");
    step(FET, P, 0, 0, 1, "R8");
    step(FET, P, 'h0C00, 0, 1, "R8");
    step(RD,  P, 40, 0, 0, "R7");
    step(RD,  P, 287, 0, 0, "R7");
    step(RD,  X, 'h0800, 0, 0, "R9");
    step(RD,  Y, 'h1FFF, 0, 0, "R9");
    step(RD,  N, 'h2E00, 0, 0, "R9");
    step(RD,  X, 'h07FF, 0, 0, "R9");
    step(WR,  X, 'h3000, 24'h999999, 0, "R10");
    step(IDL, X, 0, 0, 0, "R10");
    step(IDL, X, 0, 0, 0, "R10");
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout exp finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule